// File: doc/BRIEF.md
# Dual-Issue In-Order Add Pipeline Issue Control

This block is the issue stage of a five-stage (fetch, decode, execute, memory, write-back) pipeline that runs register-to-register add instructions on two parallel lanes. Each cycle the upstream fetch logic presents the two oldest undecoded instructions: slot 0 is the older one and slot 1 the younger one. The block decides how many of them leave decode. It reports that count on `issue_cnt`. Fetch then drops that many instructions from its queue, so an unissued slot-1 instruction is shown in slot 0 on the next cycle.

There is no forwarding. A source register that matches the destination of an older instruction still in execute or memory, in either lane, holds the instruction in decode. A result that is being written back in the current cycle passes straight into the decode read, so a consumer can issue three cycles after its producer. The register file has four read ports and two write ports. Each lane carries its own valid bit, so a lane that was not given an instruction carries a bubble and writes nothing. A free-running cycle counter, restarted by reset, measures how long a program takes.

Top module: `dual_issue_pair`

## Requirements
- R1: Both slots issue (`issue_cnt`=2) only when slot 1 reads neither of its sources from slot 0's destination and neither slot is blocked by R3. If slot 1 reads slot 0's destination, at most slot 0 issues.
- R2: Issue is in order. Slot 1 never issues unless slot 0 issues in the same cycle. A valid slot 1 shown with slot 0 invalid is ignored: `issue_cnt` is 0 and the register file is left unchanged.
- R3: An instruction does not issue while either of its source registers equals the destination of a valid instruction in the execute or memory stage of either lane.
- R4: A source equal to a destination being written back in the current cycle reads the new value, so the consumer may issue in that cycle.
- R5: An instruction issued in cycle c appears on the write-back port of its lane in cycle c+3. Slot 0 uses the wb0 lane and slot 1 the wb1 lane. The data is the sum of its two source values.
- R6: When both lanes write the same register in one cycle, the slot-1 (younger) value is the one kept, and it is the one forwarded through the write-through path.
- R7: A lane given no instruction in cycle c shows write-back valid low in cycle c+3.
- R8: `cyc_cnt` is 0 in the first cycle after reset is released and rises by one every cycle.
- R9: Reset empties both lanes (write-back valid low), clears `cyc_cnt`, and loads every register i with the value i.
- R10: The eight-instruction reference program (listed in the bench) issues with the counts 2,2,0,1,0,0,2,1. Its last write-back falls in the cycle with `cyc_cnt`=10, which is 12 cycles counting the one fetch cycle before the first decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s0_vld | input | 1 | Older decode slot holds an instruction |
| s0_rd | input | RAW | Older slot destination register |
| s0_rs | input | RAW | Older slot first source |
| s0_rt | input | RAW | Older slot second source |
| s1_vld | input | 1 | Younger decode slot holds an instruction |
| s1_rd | input | RAW | Younger slot destination register |
| s1_rs | input | RAW | Younger slot first source |
| s1_rt | input | RAW | Younger slot second source |
| issue_cnt | output | 2 | Number of slots leaving decode this cycle (0, 1, 2) |
| wb0_vld | output | 1 | Lane 0 write-back valid |
| wb0_rd | output | RAW | Lane 0 write-back register |
| wb0_data | output | DW | Lane 0 write-back value |
| wb1_vld | output | 1 | Lane 1 write-back valid |
| wb1_rd | output | RAW | Lane 1 write-back register |
| wb1_data | output | DW | Lane 1 write-back value |
| cyc_cnt | output | CYC_W | Cycles since reset release |

## Verification
The bench targets the following corner cases:
- A pair whose younger instruction reads the older one's destination. A design that pairs it anyway issues 2 and reads a stale operand.
- An older instruction that is stalled while an independent younger one waits behind it. An out-of-order design would issue the younger instruction alone.
- Hazards against a producer in lane 1's execute stage and in lane 1's memory stage. A design that checks only lane 0 would issue early and write a wrong sum.
- Two writes to one register in the same write-back cycle, read back by a later consumer. The wrong priority shows up as the older value.
- A slot-1-only presentation. A design that accepts it leaves a register altered that a later read exposes.
- The exact cycle of the consumer that issues three cycles after its producer. This catches a missing write-through path and an over-long stall.

// File: rtl/dip_pkg.sv
// Shared sizes and types for the dual-issue add pipeline.
// Assumes a small flat register file indexed by RAW bits.
package dip_pkg;
    localparam int NREG  = 16;
    localparam int RAW   = $clog2(NREG);
    localparam int DW    = 16;
    localparam int LANES = 2;
    localparam int NFLY  = 2 * LANES;   // in-flight tags: EX and MEM of each lane
    localparam int NRD   = 2 * LANES;   // register read ports

    typedef logic [RAW-1:0] ridx_t;
    typedef logic [DW-1:0]  word_t;

    typedef struct packed {
        logic  vld;
        ridx_t rd;
        ridx_t rs;
        ridx_t rt;
    } instr_t;

    typedef struct packed {
        logic  vld;
        ridx_t rd;
    } tag_t;

    // True when the instruction uses register r as a source.
    function automatic logic uses_reg(instr_t i, ridx_t r);
        return (i.rs == r) || (i.rt == r);
    endfunction
endpackage

// File: rtl/dip_regfile.sv
// Register file with NRD read ports and LANES write ports.
// A read of a register being written in the same cycle returns the new value.
// When two write ports hit one register, the higher-numbered (younger) port wins.
// Reset loads register i with the value i.
module dip_regfile
    import dip_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  ridx_t ra    [NRD],
    output word_t rdat  [NRD],
    input  logic  we    [LANES],
    input  ridx_t wa    [LANES],
    input  word_t wd    [LANES]
);
    word_t rf [NREG];

    // Storage update: later ports overwrite earlier ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) rf[i] <= word_t'(i);
        end else begin
            for (int w = 0; w < LANES; w++)
                if (we[w]) rf[wa[w]] <= wd[w];
        end
    end

    // Read with write-through, younger write port taking priority.
    always_comb begin
        for (int p = 0; p < NRD; p++) begin
            rdat[p] = rf[ra[p]];
            for (int w = 0; w < LANES; w++)
                if (we[w] && (wa[w] == ra[p])) rdat[p] = wd[w];
        end
    end
endmodule

// File: rtl/dip_hazard.sv
// Issue decision for the two decode slots.
// Assumes no forwarding: any source matching a valid EX/MEM destination blocks.
// Slot 1 issues only behind slot 0 and only if it does not read slot 0's result.
module dip_hazard
    import dip_pkg::*;
(
    input  instr_t s0,
    input  logic   s1_vld,
    input  ridx_t  s1_rs,
    input  ridx_t  s1_rt,
    input  tag_t   fly [NFLY],
    output logic   iss0,
    output logic   iss1
);
    logic blk0, blk1, pair_dep;

    // Compare each slot's sources against every in-flight destination.
    always_comb begin
        blk0 = 1'b0;
        blk1 = 1'b0;
        for (int k = 0; k < NFLY; k++) begin
            if (fly[k].vld && uses_reg(s0, fly[k].rd)) blk0 = 1'b1;
            if (fly[k].vld && ((s1_rs == fly[k].rd) || (s1_rt == fly[k].rd))) blk1 = 1'b1;
        end
        pair_dep = (s1_rs == s0.rd) || (s1_rt == s0.rd);
        iss0 = s0.vld && !blk0;
        iss1 = iss0 && s1_vld && !blk1 && !pair_dep;
    end
endmodule

// File: rtl/dip_lane.sv
// One execution lane: EX, MEM and WB registers with a valid bit per stage.
// The add is done between EX and MEM; a lane not issued carries a bubble.
module dip_lane
    import dip_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  issue,
    input  ridx_t rd,
    input  word_t opa,
    input  word_t opb,
    output tag_t  ex_tag,
    output tag_t  mem_tag,
    output logic  wb_vld,
    output ridx_t wb_rd,
    output word_t wb_data
);
    word_t ex_a, ex_b, mem_sum;

    // Advance the lane by one stage per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_tag  <= '0;
            mem_tag <= '0;
            wb_vld  <= 1'b0;
            wb_rd   <= '0;
            ex_a    <= '0;
            ex_b    <= '0;
            mem_sum <= '0;
            wb_data <= '0;
        end else begin
            ex_tag  <= '{vld: issue, rd: rd};
            ex_a    <= opa;
            ex_b    <= opb;
            mem_tag <= ex_tag;
            mem_sum <= ex_a + ex_b;
            wb_vld  <= mem_tag.vld;
            wb_rd   <= mem_tag.rd;
            wb_data <= mem_sum;
        end
    end
endmodule

// File: rtl/dual_issue_pair.sv
// Top of the dual-issue in-order add pipeline.
// Decode presents two slots (slot 0 older); issue_cnt tells fetch how many left.
// Assumes fetch re-presents unissued instructions oldest-first next cycle.
module dual_issue_pair
    import dip_pkg::*;
#(
    parameter int CYC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s0_vld,
    input  logic [RAW-1:0]   s0_rd,
    input  logic [RAW-1:0]   s0_rs,
    input  logic [RAW-1:0]   s0_rt,
    input  logic             s1_vld,
    input  logic [RAW-1:0]   s1_rd,
    input  logic [RAW-1:0]   s1_rs,
    input  logic [RAW-1:0]   s1_rt,
    output logic [1:0]       issue_cnt,
    output logic             wb0_vld,
    output logic [RAW-1:0]   wb0_rd,
    output logic [DW-1:0]    wb0_data,
    output logic             wb1_vld,
    output logic [RAW-1:0]   wb1_rd,
    output logic [DW-1:0]    wb1_data,
    output logic [CYC_W-1:0] cyc_cnt
);
    instr_t s0;
    ridx_t  ra    [NRD];
    word_t  rdat  [NRD];
    logic   we    [LANES];
    ridx_t  wa    [LANES];
    word_t  wd    [LANES];
    tag_t   fly   [NFLY];
    logic   iss   [LANES];
    ridx_t  dst   [LANES];
    logic   iss0, iss1;

    // Gather decode inputs into the shape the sub-blocks expect.
    always_comb begin
        s0     = '{vld: s0_vld, rd: s0_rd, rs: s0_rs, rt: s0_rt};
        ra[0]  = s0_rs;
        ra[1]  = s0_rt;
        ra[2]  = s1_rs;
        ra[3]  = s1_rt;
        iss[0] = iss0;
        iss[1] = iss1;
        dst[0] = s0_rd;
        dst[1] = s1_rd;
        issue_cnt = {1'b0, iss0} + {1'b0, iss1};
    end

    dip_regfile u_rf (
        .clk  (clk),
        .rst_n(rst_n),
        .ra   (ra),
        .rdat (rdat),
        .we   (we),
        .wa   (wa),
        .wd   (wd)
    );

    dip_hazard u_hz (
        .s0    (s0),
        .s1_vld(s1_vld),
        .s1_rs (s1_rs),
        .s1_rt (s1_rt),
        .fly   (fly),
        .iss0  (iss0),
        .iss1  (iss1)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        tag_t ex_t, mem_t;
        dip_lane u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .issue  (iss[l]),
            .rd     (dst[l]),
            .opa    (rdat[2*l]),
            .opb    (rdat[2*l+1]),
            .ex_tag (ex_t),
            .mem_tag(mem_t),
            .wb_vld (we[l]),
            .wb_rd  (wa[l]),
            .wb_data(wd[l])
        );
        // Publish this lane's in-flight destinations to the hazard check.
        always_comb begin
            fly[2*l]   = ex_t;
            fly[2*l+1] = mem_t;
        end
    end

    // Drive the write-back ports from the lanes.
    always_comb begin
        wb0_vld  = we[0];
        wb0_rd   = wa[0];
        wb0_data = wd[0];
        wb1_vld  = we[1];
        wb1_rd   = wa[1];
        wb1_data = wd[1];
    end

    // Cycle counter restarted by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cyc_cnt <= '0;
        else        cyc_cnt <= cyc_cnt + 1'b1;
    end
endmodule

// File: rtl/dip_checker.sv
// Temporal checks on the dual-issue pipeline ports, attached by bind.
module dip_checker
    import dip_pkg::*;
#(
    parameter int CYC_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             s0_vld,
    input logic [RAW-1:0]   s0_rd,
    input logic [RAW-1:0]   s0_rs,
    input logic [RAW-1:0]   s0_rt,
    input logic [RAW-1:0]   s1_rd,
    input logic [RAW-1:0]   s1_rs,
    input logic [RAW-1:0]   s1_rt,
    input logic [1:0]       issue_cnt,
    input logic             wb0_vld,
    input logic [RAW-1:0]   wb0_rd,
    input logic             wb1_vld,
    input logic [RAW-1:0]   wb1_rd,
    input logic [CYC_W-1:0] cyc_cnt
);
    // R1: a dependent pair never issues together
    p_pair_indep_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_cnt == 2'd2) |-> !((s1_rs == s0_rd) || (s1_rt == s0_rd)));

    // R2: nothing issues without an older instruction
    p_in_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !s0_vld |-> (issue_cnt == 2'd0));

    // R3: a consumer right behind its producer (now in EX) stays in decode
    p_ex_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_cnt != 2'd0) |=>
            (!(s0_vld && ((s0_rs == $past(s0_rd)) || (s0_rt == $past(s0_rd)))) || (issue_cnt == 2'd0)));

    // R5: slot 0 reaches lane 0 write-back three cycles after issue
    p_lat0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_cnt != 2'd0) |-> ##3 (wb0_vld && (wb0_rd == $past(s0_rd, 3))));

    // R5: slot 1 reaches lane 1 write-back three cycles after issue
    p_lat1_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_cnt == 2'd2) |-> ##3 (wb1_vld && (wb1_rd == $past(s1_rd, 3))));

    // R7: empty issue leaves both lanes empty at write-back
    p_bubble_both_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_cnt == 2'd0) |-> ##3 (!wb0_vld && !wb1_vld));

    // R7: single issue leaves lane 1 empty at write-back
    p_bubble_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_cnt == 2'd1) |-> ##3 !wb1_vld);

    // R8: cycle counter steps by one
    p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cyc_cnt == CYC_W'($past(cyc_cnt) + 1'b1)));
endmodule

bind dual_issue_pair dip_checker #(.CYC_W(CYC_W)) u_chk (.*);

// File: tb/dual_issue_pair_test.sv
`timescale 1ns/1ps
module dual_issue_pair_test;
    import dip_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n;
    logic s0_vld, s1_vld;
    logic [RAW-1:0] s0_rd, s0_rs, s0_rt, s1_rd, s1_rs, s1_rt;
    logic [1:0] issue_cnt;
    logic wb0_vld, wb1_vld;
    logic [RAW-1:0] wb0_rd, wb1_rd;
    logic [DW-1:0] wb0_data, wb1_data;
    logic [15:0] cyc_cnt;

    dual_issue_pair #(.CYC_W(16)) uut (.*);

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Program storage and per-cycle observations
    int p_rd[8], p_rs[8], p_rt[8];
    int o_iss[16], o_w0v[16], o_w0rd[16], o_w0d[16], o_w1v[16], o_w1rd[16], o_w1d[16], o_cnt[16];

    // Reference program, expected per cycle (R10, R5, R4, R3, R1)
    localparam int NC = 12;
    localparam int E_ISS [NC] = '{2,2,0,1,0,0,2,1,0,0,0,0};
    localparam int E_W0V [NC] = '{0,0,0,1,1,0,1,0,0,1,1,0};
    localparam int E_W0RD[NC] = '{0,0,0,1,6,0,4,0,0,5,2,0};
    localparam int E_W0D [NC] = '{0,0,0,8,6,0,15,0,0,22,13,0};
    localparam int E_W1V [NC] = '{0,0,0,1,1,0,0,0,0,1,0,0};
    localparam int E_W1RD[NC] = '{0,0,0,9,3,0,0,0,0,9,0,0};
    localparam int E_W1D [NC] = '{0,0,0,5,7,0,0,0,0,13,0,0};

    task automatic do_reset();
        rst_n = 1'b0;
        s0_vld = 1'b0; s1_vld = 1'b0;
        s0_rd = '0; s0_rs = '0; s0_rt = '0;
        s1_rd = '0; s1_rs = '0; s1_rt = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Feeds n program entries in order, advancing by issue_cnt each cycle.
    task automatic run_prog(input int n, input int ncyc);
        int idx = 0;
        for (int k = 0; k < ncyc; k++) begin
            s0_vld = (idx < n);
            s1_vld = (idx + 1 < n);
            if (idx < n) begin
                s0_rd = RAW'(p_rd[idx]); s0_rs = RAW'(p_rs[idx]); s0_rt = RAW'(p_rt[idx]);
            end
            if (idx + 1 < n) begin
                s1_rd = RAW'(p_rd[idx+1]); s1_rs = RAW'(p_rs[idx+1]); s1_rt = RAW'(p_rt[idx+1]);
            end
            #1;
            o_iss[k] = int'(issue_cnt);
            o_w0v[k] = int'(wb0_vld); o_w0rd[k] = int'(wb0_rd); o_w0d[k] = int'(wb0_data);
            o_w1v[k] = int'(wb1_vld); o_w1rd[k] = int'(wb1_rd); o_w1d[k] = int'(wb1_data);
            o_cnt[k] = int'(cyc_cnt);
            idx += int'(issue_cnt);
            @(negedge clk);
        end
        s0_vld = 1'b0; s1_vld = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        // Reset state (R9, R8)
        rst_n = 1'b0;
        s0_vld = 1'b0; s1_vld = 1'b0;
        s0_rd = '0; s0_rs = '0; s0_rt = '0;
        s1_rd = '0; s1_rs = '0; s1_rt = '0;
        repeat (3) @(negedge clk);
        #1;
        chk("R9 wb0 empty in reset", int'(wb0_vld), 0);
        chk("R9 wb1 empty in reset", int'(wb1_vld), 0);
        chk("R9 counter in reset", int'(cyc_cnt), 0);
        chk("R2 no issue without slot0", int'(issue_cnt), 0);

        // Reference program: regs hold their own index after reset (R9)
        p_rd = '{1,9,6,3,4,5,9,2};
        p_rs = '{3,2,3,4,7,7,3,7};
        p_rt = '{5,3,3,3,1,4,6,6};
        do_reset();
        run_prog(8, NC);
        for (int k = 0; k < NC; k++) begin
            chk($sformatf("R10 issue count cyc%0d", k), o_iss[k], E_ISS[k]);
            chk($sformatf("R8 counter cyc%0d", k), o_cnt[k], k);
            chk($sformatf("R7 wb0 valid cyc%0d", k), o_w0v[k], E_W0V[k]);
            chk($sformatf("R7 wb1 valid cyc%0d", k), o_w1v[k], E_W1V[k]);
            if (E_W0V[k] != 0) begin
                chk($sformatf("R5 wb0 reg cyc%0d", k), o_w0rd[k], E_W0RD[k]);
                chk($sformatf("R5 wb0 data cyc%0d", k), o_w0d[k], E_W0D[k]);
            end
            if (E_W1V[k] != 0) begin
                chk($sformatf("R5 wb1 reg cyc%0d", k), o_w1rd[k], E_W1RD[k]);
                chk($sformatf("R5 wb1 data cyc%0d", k), o_w1d[k], E_W1D[k]);
            end
        end
        chk("R10 total cycles incl fetch", o_cnt[10] + 2, 12);
        chk("R4 write-through consumer issues at cyc3", o_iss[3], 1);

        // Same-register pair, younger wins; consumer reads through write-through (R6)
        p_rd[0] = 10; p_rs[0] = 1; p_rt[0] = 2;
        p_rd[1] = 10; p_rs[1] = 3; p_rt[1] = 4;
        p_rd[2] = 11; p_rs[2] = 10; p_rt[2] = 0;
        do_reset();
        run_prog(3, 8);
        chk("R6 pair issues", o_iss[0], 2);
        chk("R3 consumer stalls on lane1 EX", o_iss[1], 0);
        chk("R4 consumer issues at write-back", o_iss[3], 1);
        chk("R6 older lane value", o_w0d[3], 3);
        chk("R6 younger lane value", o_w1d[3], 7);
        chk("R6 consumer sees younger", o_w0d[6], 7);

        // Split pair then in-order hold behind stalled slot0 (R1, R2, R3)
        p_rd[0] = 1; p_rs[0] = 2; p_rt[0] = 3;
        p_rd[1] = 4; p_rs[1] = 1; p_rt[1] = 1;
        p_rd[2] = 5; p_rs[2] = 2; p_rt[2] = 2;
        do_reset();
        run_prog(3, 8);
        chk("R1 dependent pair splits", o_iss[0], 1);
        chk("R2 younger waits behind stalled older", o_iss[1], 0);
        chk("R3 still stalled on MEM", o_iss[2], 0);
        chk("R1 independent pair issues", o_iss[3], 2);
        chk("R5 split older data", o_w0d[3], 5);
        chk("R5 consumer data", o_w0d[6], 10);
        chk("R5 younger data", o_w1d[6], 4);

        // Hazard against lane1 in MEM (R3)
        p_rd[0] = 1; p_rs[0] = 2; p_rt[0] = 3;
        p_rd[1] = 6; p_rs[1] = 7; p_rt[1] = 7;
        p_rd[2] = 8; p_rs[2] = 6; p_rt[2] = 6;
        do_reset();
        run_prog(3, 8);
        chk("R3 lane1 EX stall", o_iss[1], 0);
        chk("R3 lane1 MEM stall", o_iss[2], 0);
        chk("R3 issue at write-back", o_iss[3], 1);
        chk("R3 consumer data", o_w0d[6], 28);

        // Slot1 alone is ignored (R2, R7)
        do_reset();
        s1_vld = 1'b1; s1_rd = 4'd12; s1_rs = 4'd1; s1_rt = 4'd1;
        #1;
        chk("R2 slot1 alone not issued", int'(issue_cnt), 0);
        @(negedge clk);
        s1_vld = 1'b0;
        for (int k = 0; k < 4; k++) begin
            #1;
            chk("R7 no write-back after ignored slot1", int'(wb0_vld) + int'(wb1_vld), 0);
            @(negedge clk);
        end
        p_rd[0] = 13; p_rs[0] = 12; p_rt[0] = 0;
        run_prog(1, 5);
        chk("R2 register untouched", o_w0d[3], 12);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule